// File: doc/BRIEF.md
# Four-Digit Seven-Segment Scanner

This block drives four seven-segment digits that share one 8-bit segment bus. It shows one digit at a time. A one-hot column bus selects the digit that is lit. Each 4-bit digit value is turned into an active-low segment pattern through a fixed hexadecimal table, so the values 0 through F can all be shown.

A two-stage prescaler sets the display slot. One stage counts clocks into ticks and the other counts ticks into a slot. At the end of each slot the block performs a fixed switch sequence:
- All columns go dark.
- One clock later the segment register loads the pattern of the next digit. The digit value is captured at that moment.
- One clock after that, the matching column turns on.

The digits are scanned in the order 0, 1, 2, 3 and the scan then repeats. After reset the display stays dark until the first slot expires, and digit 0 is shown first. The full slot must be at least 3 clocks long.

Top module: `segscan_top`

## Requirements
- R1: While reset is high, and after reset until the first slot expires, `col_o` is 0 and `seg_o` is 8'hFF. A 1 on a segment line means that segment is off. The first digit shown is digit 0, on column bit 0.
- R2: Let P = TICK_CLKS*TICKS_PER_SLOT. After reset is released, the first column turns on after the P+2-th rising edge. Successive column turn-ons are exactly P clocks apart.
- R3: A digit value v is shown with these segment codes: 0=05, 1=DD, 2=86, 3=94, 4=5C, 5=34, 6=24, 7=9D, 8=04, 9=14, A=0C, B=64, C=27, D=C4, E=26, F=2E (hex).
- R4: At most one bit of `col_o` is high at any time. Column bit i shows digit i, which is taken from `digits_i[4*i+3:4*i]`.
- R5: The column that turns on is always the next one after the column that was lit before it, in the order 0,1,2,3,0.
- R6: At every switch, all columns stay off for exactly 2 clocks. `seg_o` changes only while all columns are off. A new pattern is on `seg_o` one clock before its column turns on.
- R7: The digit value is captured only at the load step of a switch. A change on `digits_i` at any other time has no effect on `seg_o` until the next switch.
- R8: Each column stays lit for exactly P-2 clocks per slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_i | input | NUM_DIGITS*4 | Digit values; digit i is in bits 4i+3..4i |
| seg_o | output | 8 | Active-low segment pattern |
| col_o | output | NUM_DIGITS | One-hot column select, active high |

## Verification
Two functions can act in the same cycle: a new digit value arriving on `digits_i`, and the load step that captures a digit value. The bench drives new digit values in the blank gap just before a load, and checks that the fresh value is shown. It also changes the value in the middle of a lit slot and checks that `seg_o` does not move. This shows that only the load step samples the input. Reset is also asserted in the middle of a lit slot, and the bench checks that the display returns to dark at once and that the scan restarts at digit 0.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

    localparam int SEG_W = 8;
    localparam int NIB_W = 4;
    localparam logic [SEG_W-1:0] SEG_DARK = 8'hFF;

    typedef enum logic [1:0] {
        PH_SHOW = 2'd0,
        PH_LOAD = 2'd1,
        PH_ARM  = 2'd2
    } phase_t;

    typedef struct packed {
        logic blank;
        logic load;
        logic arm;
    } step_t;

    function automatic logic [SEG_W-1:0] hex_to_seg(input logic [NIB_W-1:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'h0: s = 8'h05;
            4'h1: s = 8'hDD;
            4'h2: s = 8'h86;
            4'h3: s = 8'h94;
            4'h4: s = 8'h5C;
            4'h5: s = 8'h34;
            4'h6: s = 8'h24;
            4'h7: s = 8'h9D;
            4'h8: s = 8'h04;
            4'h9: s = 8'h14;
            4'hA: s = 8'h0C;
            4'hB: s = 8'h64;
            4'hC: s = 8'h27;
            4'hD: s = 8'hC4;
            4'hE: s = 8'h26;
            default: s = 8'h2E;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scan_pace.sv
module scan_pace #(
    parameter int TICK_CLKS      = 200,
    parameter int TICKS_PER_SLOT = 20
) (
    input  logic clk,
    input  logic rst,
    output logic slot_end
);
    localparam int TW = $clog2(TICK_CLKS + 1);
    localparam int SW = $clog2(TICKS_PER_SLOT + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CLKS - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(TICKS_PER_SLOT - 1);

    logic [TW-1:0] clk_cnt_q;
    logic [SW-1:0] tick_cnt_q;
    logic          tick;

    assign tick     = (clk_cnt_q == TICK_LAST);
    assign slot_end = tick && (tick_cnt_q == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_cnt_q  <= '0;
            tick_cnt_q <= '0;
        end else begin
            clk_cnt_q <= tick ? '0 : clk_cnt_q + 1'b1;
            if (tick) begin
                tick_cnt_q <= (tick_cnt_q == SLOT_LAST) ? '0 : tick_cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import segscan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_end,
    output step_t         step,
    output logic [IW-1:0] sel_idx
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_DIGITS - 1);

    phase_t        phase_q;
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_next;

    assign ptr_next   = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    assign step.blank = (phase_q == PH_SHOW) && slot_end;
    assign step.load  = (phase_q == PH_LOAD);
    assign step.arm   = (phase_q == PH_ARM);
    assign sel_idx    = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SHOW;
            ptr_q   <= LAST_IDX;
        end else begin
            case (phase_q)
                PH_SHOW: if (slot_end) begin
                    phase_q <= PH_LOAD;
                    ptr_q   <= ptr_next;
                end
                PH_LOAD: phase_q <= PH_ARM;
                default: phase_q <= PH_SHOW;
            endcase
        end
    end
endmodule

// File: rtl/scan_out.sv
module scan_out
    import segscan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  step_t                       step,
    input  logic [IW-1:0]               sel_idx,
    input  logic [NUM_DIGITS*NIB_W-1:0] digits_i,
    output logic [SEG_W-1:0]            seg_o,
    output logic [NUM_DIGITS-1:0]       col_o
);
    logic [NIB_W-1:0]      nib_arr [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] sel_hot;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_lane
        assign nib_arr[g] = digits_i[g*NIB_W +: NIB_W];
        assign sel_hot[g] = (sel_idx == IW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_o <= SEG_DARK;
            col_o <= '0;
        end else begin
            if (step.load) begin
                seg_o <= hex_to_seg(nib_arr[sel_idx]);
            end
            if (step.blank) begin
                col_o <= '0;
            end else if (step.arm) begin
                col_o <= sel_hot;
            end
        end
    end
endmodule

// File: rtl/segscan_top.sv
module segscan_top
    import segscan_pkg::*;
#(
    parameter int NUM_DIGITS     = 4,
    parameter int TICK_CLKS      = 200,
    parameter int TICKS_PER_SLOT = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_DIGITS*NIB_W-1:0] digits_i,
    output logic [SEG_W-1:0]            seg_o,
    output logic [NUM_DIGITS-1:0]       col_o
);
    localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    logic          slot_end;
    step_t         step;
    logic [IW-1:0] sel_idx;

    scan_pace #(
        .TICK_CLKS     (TICK_CLKS),
        .TICKS_PER_SLOT(TICKS_PER_SLOT)
    ) u_pace (
        .clk     (clk),
        .rst     (rst),
        .slot_end(slot_end)
    );

    scan_seq #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .slot_end(slot_end),
        .step    (step),
        .sel_idx (sel_idx)
    );

    scan_out #(.NUM_DIGITS(NUM_DIGITS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .sel_idx (sel_idx),
        .digits_i(digits_i),
        .seg_o   (seg_o),
        .col_o   (col_o)
    );
endmodule

// File: rtl/segscan_chk.sv
module segscan_chk #(
    parameter int NUM_DIGITS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [7:0]            seg_o,
    input logic [NUM_DIGITS-1:0] col_o
);
    logic [NUM_DIGITS-1:0] last_lit_q;
    logic                  seen_q;
    logic [NUM_DIGITS-1:0] exp_next;

    assign exp_next = {last_lit_q[NUM_DIGITS-2:0], last_lit_q[NUM_DIGITS-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            last_lit_q <= '0;
            seen_q     <= 1'b0;
        end else if (col_o != '0) begin
            last_lit_q <= col_o;
            seen_q     <= 1'b1;
        end
    end

    AST_RESET_DARK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (col_o == '0 && seg_o == 8'hFF)); // R1

    AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_o)); // R4

    AST_ROTATE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (col_o != '0 && $past(col_o) == '0 && seen_q) |-> (col_o == exp_next)); // R5

    AST_FIRST_DIGIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (col_o != '0 && !seen_q) |-> col_o[0]); // R1

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
        (col_o != '0 && $past(col_o) != '0) |-> (col_o == $past(col_o))); // R6

    AST_SEG_MOVES_DARK: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_o) |-> (col_o == '0)); // R6

    AST_SEG_SETTLED_LIT: assert property (@(posedge clk) disable iff (rst)
        (col_o != '0) |-> $stable(seg_o)); // R7
endmodule

bind segscan_top segscan_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .seg_o(seg_o),
    .col_o(col_o)
);

// File: tb/test_segscan_top.sv
`timescale 1ns/1ps
module test_segscan_top;
    localparam int ND  = 4;
    localparam int TC  = 3;
    localparam int TS  = 2;
    localparam int P   = TC * TS;

    // {value, segment code}
    localparam logic [11:0] VEC [16] = '{
        {4'h0, 8'h05}, {4'h1, 8'hDD}, {4'h2, 8'h86}, {4'h3, 8'h94},
        {4'h4, 8'h5C}, {4'h5, 8'h34}, {4'h6, 8'h24}, {4'h7, 8'h9D},
        {4'h8, 8'h04}, {4'h9, 8'h14}, {4'hA, 8'h0C}, {4'hB, 8'h64},
        {4'hC, 8'h27}, {4'hD, 8'hC4}, {4'hE, 8'h26}, {4'hF, 8'h2E}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   digits = 16'h4321;
    logic [7:0]    seg;
    logic [ND-1:0] col;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    segscan_top #(.NUM_DIGITS(ND), .TICK_CLKS(TC), .TICKS_PER_SLOT(TS)) i_segscan_top (
        .clk(clk), .rst(rst), .digits_i(digits), .seg_o(seg), .col_o(col)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code_of(input logic [3:0] v);
        return VEC[v][7:0];
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // wait for next column turn-on; returns negedges waited
    task automatic wait_on(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (col == '0);
    endtask

    // count lit negedges (first already seen); checks seg holds
    task automatic lit_len(output int n, input logic [7:0] held);
        n = 1;
        forever begin
            @(negedge clk);
            if (col == '0) break;
            n++;
            chk(seg == held, "R7 seg held while lit", seg, held);
        end
    endtask

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        int e;
        int lit;
        repeat (3) @(negedge clk);
        chk(col == '0 && seg == 8'hFF, "R1 dark during reset", {seg, col}, {8'hFF, 4'h0});
        rst = 1'b0;
        // R1/R6: dark through negedge P+1, seg loads at edge P+1
        for (int k = 1; k <= P + 1; k++) begin
            @(negedge clk);
            chk(col == '0, "R1 columns off before first slot", col, 0);
            if (k <= P)
                chk(seg == 8'hFF, "R1 segments dark before first load", seg, 8'hFF);
        end
        chk(seg == code_of(4'h1), "R6 pattern ready before column", seg, code_of(4'h1));
        @(negedge clk);
        chk(col == 4'b0001, "R1 R2 digit 0 on after P+2 edges", col, 1);
        chk(seg == code_of(4'h1), "R3 digit 0 code", seg, code_of(4'h1));
        lit_len(lit, code_of(4'h1));
        chk(lit == P - 2, "R8 lit time", lit, P - 2);

        // vector walk: every code, rotation, blank gap, period
        e = 1;
        for (int i = 0; i < 16; i++) begin
            digits = {4{VEC[i][11:8]}};
            wait_on(n);
            chk(n == 2, "R6 blank gap two clocks", n, 2);
            chk(col == ND'(1 << e), "R5 rotation order", col, 1 << e);
            chk(seg == VEC[i][7:0], "R3 segment code", seg, VEC[i][7:0]);
            digits = ~digits;
            lit_len(lit, VEC[i][7:0]);
            chk(lit + n == P, "R2 R8 slot period", lit + n, P);
            e = (e + 1) % ND;
        end

        // distinct digits per column
        digits = 16'hDCBA;
        for (int j = 0; j < ND; j++) begin
            wait_on(n);
            chk(col == ND'(1 << e), "R4 column select", col, 1 << e);
            chk(seg == code_of(digits[4*e +: 4]), "R4 digit lane", seg, code_of(digits[4*e +: 4]));
            lit_len(lit, code_of(digits[4*e +: 4]));
            e = (e + 1) % ND;
        end

        // reset in the middle of a lit slot
        wait_on(n);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(col == '0 && seg == 8'hFF, "R1 reset mid-slot dark", {seg, col}, {8'hFF, 4'h0});
        rst = 1'b0;
        digits = 16'h0007;
        wait_on(n);
        chk(n == P + 2, "R2 restart timing", n, P + 2);
        chk(col == 4'b0001 && seg == code_of(4'h7), "R1 restart at digit 0", {seg, col}, {code_of(4'h7), 4'h1});
        summary();
    end
endmodule